// File: doc/BRIEF.md
# System Control Register File

A bank of 32-bit control and status words sitting behind a simple APB-style slave port. An access happens in every cycle where both select and enable are high. The byte address is turned into a word index by discarding its two least significant bits. Read data is registered and comes back one cycle after the access, together with a read-valid strobe.

Several words have fixed roles. Two PLL status words come out of reset holding fixed values, and one of them cannot be written. Three remap control words (embedded SRAM, DDR, NVM base) always read back their reset value of zero, because writes to them are discarded. A clock control word is loaded at reset with codes derived from two peripheral-bus divisor parameters. Each divisor must be a power of two no larger than 32, and an illegal value stops elaboration.

Any access whose word index lies past the end of the bank raises a one-cycle error pulse, leaves the storage untouched and, for a read, returns zero.

Top module: `sysctl_regfile`

## Requirements
- R1: Word index is paddr[ADDR_W-1:2], so the two low address bits never select a different word. Every word other than the PLL status word and the three remap words is a plain 32-bit read/write register, including the clock control and PLL low status words.
- R2: After reset, word PLL_LO_IDX (default 37) reads 0x021A2358, word PLL_STAT_IDX (default 38) reads 0x00000003, and every word apart from these two and CLKCTL_IDX reads zero.
- R3: Each divisor is encoded as its trailing-zero count if below 8, and as that count plus one otherwise (1→0, 2→1, 4→2, 8→4, 16→5, 32→6). After reset, word CLKCTL_IDX (default 18) holds (code(DIV_A) << 5) | (code(DIV_B) << 2), which is 0x24 for the defaults.
- R4: A write to the PLL status word has no effect, and the word keeps reading 0x3.
- R5: Writes to the remap words (default indices 0, 1 and 4) have no effect, and these words always read zero.
- R6: A read at a word index of NUM_WORDS (64) or above returns zero in prdata and pulses err in the following cycle.
- R7: A write at a word index of NUM_WORDS or above changes no stored word and pulses err in the following cycle.
- R8: prdata and rd_vld update in the cycle after a read access. rd_vld is high only after reads. err is high only in the cycle after an out-of-range access, and is never high after an in-range access or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access enable; access when psel and penable are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (10) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| rd_vld | output | 1 | Read data valid, one cycle after a read access |
| err | output | 1 | One-cycle pulse after an out-of-range access |

## Verification
The error pulse of one access and the read return of the access before it can meet in the same cycle if accesses run back to back. To provoke this, the bench issues an in-range read immediately followed by an out-of-range read. It then checks three things: err is low while the first read's data is returned, err goes high exactly with the second read's result, and prdata is zero at that point. Random traffic mixes in-range and out-of-range addresses with all four byte offsets, and every result is compared against a reference model of the bank.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int          DATA_W         = 32,
  parameter int          NUM_WORDS      = 64,
  parameter int          ADDR_W         = 10,
  parameter int          DIV_A          = 2,
  parameter int          DIV_B          = 2,
  parameter int          CLKCTL_IDX     = 18,
  parameter int          PLL_LO_IDX     = 37,
  parameter int          PLL_STAT_IDX   = 38,
  parameter int          REMAP_SRAM_IDX = 0,
  parameter int          REMAP_DDR_IDX  = 1,
  parameter int          REMAP_NVM_IDX  = 4,
  parameter logic [31:0] PLL_LO_RST     = 32'h021A_2358,
  parameter logic [31:0] PLL_STAT_RST   = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              rd_vld,
  output logic              err
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = $clog2(NUM_WORDS);

  function automatic bit legal_div(int d);
    return (d >= 1) && (d <= 32) && ((d & (d - 1)) == 0);
  endfunction

  function automatic int div_code(int d);
    int tz = 0;
    for (int b = 0; b < 6; b++)
      if (d == (1 << b)) tz = b;
    return (d < 8) ? tz : tz + 1;
  endfunction

  localparam logic [DATA_W-1:0] CLKCTL_RST =
    DATA_W'((div_code(DIV_A) << 5) | (div_code(DIV_B) << 2));

  function automatic logic [DATA_W-1:0] reset_word(int i);
    if (i == CLKCTL_IDX)   return CLKCTL_RST;
    if (i == PLL_LO_IDX)   return DATA_W'(PLL_LO_RST);
    if (i == PLL_STAT_IDX) return DATA_W'(PLL_STAT_RST);
    return '0;
  endfunction

  function automatic bit locked(int i);
    return (i == PLL_STAT_IDX) || (i == REMAP_SRAM_IDX) ||
           (i == REMAP_DDR_IDX) || (i == REMAP_NVM_IDX);
  endfunction

  if (!legal_div(DIV_A) || !legal_div(DIV_B)) begin : g_bad_div
    $error("divisor parameters must be powers of two no larger than 32");
  end

  logic [IDX_W-1:0] idx;
  logic             acc;
  logic             in_rng;
  logic             wr_hit;
  logic [1:0]       unused_lsb;

  assign idx        = paddr[ADDR_W-1:2];
  assign unused_lsb = paddr[1:0];
  assign acc        = psel & penable;
  assign in_rng     = (int'(idx) < NUM_WORDS);
  assign wr_hit     = acc & pwrite & in_rng;

  logic [NUM_WORDS-1:0][DATA_W-1:0] words;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam logic [DATA_W-1:0] RV = reset_word(i);
    if (locked(i)) begin : g_ro
      assign words[i] = RV;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= RV;
        else if (wr_hit && (int'(idx) == i))
          q <= pwdata;
      end
      assign words[i] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prdata <= '0;
      rd_vld <= 1'b0;
      err    <= 1'b0;
    end else begin
      rd_vld <= acc & ~pwrite;
      err    <= acc & ~in_rng;
      if (acc && !pwrite)
        prdata <= in_rng ? words[idx[SEL_W-1:0]] : '0;
    end
  end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int          DATA_W         = 32,
  parameter int          NUM_WORDS      = 64,
  parameter int          ADDR_W         = 10,
  parameter int          PLL_STAT_IDX   = 38,
  parameter int          REMAP_SRAM_IDX = 0,
  parameter int          REMAP_DDR_IDX  = 1,
  parameter int          REMAP_NVM_IDX  = 4,
  parameter logic [31:0] PLL_STAT_RST   = 32'h3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              rd_vld,
  input logic              err
);
  logic acc, rd, oob, remap;
  int   w;
  assign w     = int'(paddr[ADDR_W-1:2]);
  assign acc   = psel && penable;
  assign rd    = acc && !pwrite;
  assign oob   = w >= NUM_WORDS;
  assign remap = (w == REMAP_SRAM_IDX) || (w == REMAP_DDR_IDX) || (w == REMAP_NVM_IDX);

  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_vld);
  assert_no_stray_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && oob) |=> !err);
  assert_oob_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && oob |=> err);
  assert_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && oob |=> prdata == '0);
  assert_pll_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (w == PLL_STAT_IDX) |=> prdata == DATA_W'(PLL_STAT_RST));
  assert_remap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd && remap |=> prdata == '0);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
  .PLL_STAT_IDX(PLL_STAT_IDX), .REMAP_SRAM_IDX(REMAP_SRAM_IDX),
  .REMAP_DDR_IDX(REMAP_DDR_IDX), .REMAP_NVM_IDX(REMAP_NVM_IDX),
  .PLL_STAT_RST(PLL_STAT_RST)
) u_chk (.*);

// File: tb/sysctl_regfile_bench.sv
`timescale 1ns/1ps
module sysctl_regfile_bench;
  localparam int NW = 64;
  localparam int CLK_I = 18, PLO_I = 37, PST_I = 38, RS_I = 0, RD_I = 1, RN_I = 4;

  logic        clk = 0, rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_a, prdata_b;
  logic        rd_vld, err, rdv_a, err_a, rdv_b, err_b;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] model [NW];

  always #2 clk = ~clk;

  sysctl_regfile #(.CLKCTL_IDX(CLK_I), .PLL_LO_IDX(PLO_I), .PLL_STAT_IDX(PST_I),
    .REMAP_SRAM_IDX(RS_I), .REMAP_DDR_IDX(RD_I), .REMAP_NVM_IDX(RN_I)) u_sysctl_regfile (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata(prdata), .rd_vld(rd_vld), .err(err));
  sysctl_regfile #(.DIV_A(32), .DIV_B(8)) u_alt_a (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata(prdata_a), .rd_vld(rdv_a), .err(err_a));
  sysctl_regfile #(.DIV_A(1), .DIV_B(16)) u_alt_b (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata(prdata_b), .rd_vld(rdv_b), .err(err_b));

  function automatic int code_of(int d);
    case (d)
      1: return 0;  2: return 1;  4: return 2;
      8: return 4;  16: return 5; 32: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] rst_exp(int i);
    if (i == CLK_I) return 32'((code_of(2) << 5) | (code_of(2) << 2));
    if (i == PLO_I) return 32'h021A2358;
    if (i == PST_I) return 32'h3;
    return 32'h0;
  endfunction

  function automatic bit ro(int i);
    return i == PST_I || i == RS_I || i == RD_I || i == RN_I;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(bit w, logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic model_acc(bit w, logic [9:0] a, logic [31:0] d);
    int i;
    i = int'(a[9:2]);
    acc(w, a, d);
    chk("R6/R7 err", {31'b0, err}, {31'b0, i >= NW});
    chk("R8 rd_vld", {31'b0, rd_vld}, {31'b0, !w});
    if (w) begin
      if (i < NW && !ro(i)) model[i] = d;
    end else begin
      chk("R1/R6 rdata", prdata, i < NW ? model[i] : 32'h0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NW; i++) model[i] = rst_exp(i);
    repeat (3) @(negedge clk);
    chk("R8 reset err", {31'b0, err}, 32'h0);
    chk("R8 reset rd_vld", {31'b0, rd_vld}, 32'h0);
    rst_n = 1;

    // R2 R3 R5: reset contents of every word
    for (int i = 0; i < NW; i++) begin
      acc(0, 10'(i * 4), 0);
      chk($sformatf("R2 reset word %0d", i), prdata, rst_exp(i));
      if (i == CLK_I) begin
        chk("R3 clkctl 32/8", prdata_a, 32'((code_of(32) << 5) | (code_of(8) << 2)));
        chk("R3 clkctl 1/16", prdata_b, 32'((code_of(1) << 5) | (code_of(16) << 2)));
      end
    end

    // R4: PLL status ignores writes
    model_acc(1, 10'(PST_I * 4), 32'hFFFF_FFFF);
    model_acc(0, 10'(PST_I * 4), 0);
    chk("R4 pll status", prdata, 32'h3);

    // R5: remap words ignore writes
    model_acc(1, 10'(RS_I * 4), 32'hDEAD_BEEF);
    model_acc(1, 10'(RD_I * 4 + 2), 32'h1234_5678);
    model_acc(1, 10'(RN_I * 4), 32'hFFFF_FFFF);
    model_acc(0, 10'(RS_I * 4), 0); chk("R5 remap sram", prdata, 0);
    model_acc(0, 10'(RD_I * 4), 0); chk("R5 remap ddr", prdata, 0);
    model_acc(0, 10'(RN_I * 4 + 3), 0); chk("R5 remap nvm", prdata, 0);

    // R1: clock control and PLL low writable; low address bits ignored
    model_acc(1, 10'(CLK_I * 4 + 1), 32'hA5A5_0F0F);
    model_acc(0, 10'(CLK_I * 4 + 3), 0); chk("R1 clkctl rw", prdata, 32'hA5A5_0F0F);
    model_acc(1, 10'(PLO_I * 4), 32'h0BAD_F00D);
    model_acc(0, 10'(PLO_I * 4 + 2), 0); chk("R1 pll low rw", prdata, 32'h0BAD_F00D);

    // R7: out-of-range write leaves aliased word alone
    model_acc(1, 10'(5 * 4), 32'h5555_5555);
    model_acc(1, 10'((NW + 5) * 4), 32'hCCCC_CCCC);
    chk("R7 oob write err", {31'b0, err}, 1);
    model_acc(0, 10'(5 * 4), 0); chk("R7 word 5 kept", prdata, 32'h5555_5555);

    // R6: out-of-range read
    model_acc(0, 10'h3FC, 0);
    chk("R6 oob read zero", prdata, 0);

    // R8: back-to-back in-range read then out-of-range read
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 0; paddr = 10'(5 * 4);
    @(negedge clk);
    paddr = 10'((NW + 1) * 4);
    chk("R8 b2b first data", prdata, 32'h5555_5555);
    chk("R8 b2b first no err", {31'b0, err}, 0);
    @(negedge clk);
    psel = 0; penable = 0;
    chk("R8 b2b second err", {31'b0, err}, 1);
    chk("R6 b2b second zero", prdata, 0);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, err}, 0);
    chk("R8 idle rd_vld", {31'b0, rd_vld}, 0);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [9:0] a;
      bit w;
      w = ($urandom % 2) == 1;
      if ($urandom % 4 == 0) a = 10'($urandom);
      else a = {8'($urandom % NW), 2'($urandom)};
      model_acc(w, a, $urandom);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule